// File: doc/BRIEF.md
# Vector Mask Population Count and First-Set Search

This block scans two packed mask vectors, a source mask and a governing mask, up to a vector length, and returns a 32-bit scalar. In count mode the scalar is the number of active elements. In find-first mode it is the index of the lowest active element, or all ones when no element is active. An element is active when its source bit and its governing bit are both 1 and its index is below the vector length.

A one-cycle start pulse issues an operation. The pulse carries the op select, both masks, the vector length and a flag that reports a nonzero start position. The block latches the masks and works through them one byte (eight elements) per cycle. It reports the answer with a one-cycle done pulse, and an exception flag rides on that pulse. A nonzero start position is not supported, so it produces an exception and no result.

Top module: `vmask_scan`

## Requirements
- R1: Element i of a packed mask is bit i of the input vector: bit (i mod 8) of byte (i div 8), so element 0 is the LSB of byte 0.
- R2: An element counts as active only when its `src_i` bit and its `gov_i` bit are both 1.
- R3: Elements with an index equal to or above the effective vector length never affect the result.
- R4: With `op_i`=0 (count), `result_o` is the number of active elements as a zero-extended unsigned value.
- R5: With `op_i`=1 (find-first), `result_o` is the lowest active index, or 32'hFFFF_FFFF when no element is active.
- R6: When `vstart_nz_i`=1 at issue, the block does not scan. It pulses `done_o` with `exc_o`=1 and `result_o`=0 one cycle after the start edge. `exc_o` is never 1 without `done_o`.
- R7: With a vector length of 0, the block pulses `done_o` one cycle after the start edge. The result is 0 in count mode and all ones in find-first mode.
- R8: A `vl_i` above MAX_VL is treated as MAX_VL.
- R9: A `start_i` pulse that arrives while a scan is in progress is ignored. It produces no extra done pulse and does not change the running result.
- R10: The block examines one byte per cycle. `done_o` rises in the cycle after the last needed byte: byte ceil(vl/8)-1 in count mode or on a miss, and the byte that holds the first hit in find-first mode.
- R11: After reset, `done_o`, `exc_o` and `result_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Issue pulse, honoured only when idle |
| op_i | input | 1 | 0 = count, 1 = find-first |
| src_i | input | MAX_VL | Packed source mask |
| gov_i | input | MAX_VL | Packed governing mask |
| vl_i | input | 32 | Vector length in elements |
| vstart_nz_i | input | 1 | Start position is nonzero |
| done_o | output | 1 | Result valid pulse |
| result_o | output | 32 | Count or first index |
| exc_o | output | 1 | Exception, valid with done_o |

## Verification
The assertions hold on every cycle for the following properties:
- The exception flag appears only on a done pulse and with a zero result.
- The byte pointer advances by one per busy cycle.
- The running count never decreases during a scan.
- A reported count never exceeds the latched length.
- A reported index always lies below the latched length.

Only the bench scenarios can show the exact values. These cover the lane-to-bit mapping, the AND of the two masks, clamping, the early stop on a hit, the exact latency, and the absence of any response to a start pulse issued mid-scan.

// File: rtl/vmask_scan_pkg.sv
package vmask_scan_pkg;

  typedef enum logic {
    OP_COUNT = 1'b0,
    OP_FIRST = 1'b1
  } scan_op_e;

  // number of ones in one byte of live elements
  function automatic logic [3:0] ones_in_byte(input logic [7:0] b);
    logic [3:0] n;
    n = '0;
    for (int k = 0; k < 8; k++) n = n + {3'b000, b[k]};
    return n;
  endfunction

  // offset of the lowest set bit of a byte (0 when none)
  function automatic logic [2:0] low_bit(input logic [7:0] b);
    logic [2:0] p;
    p = '0;
    for (int k = 7; k >= 0; k--) if (b[k]) p = 3'(k);
    return p;
  endfunction

endpackage

// File: rtl/vmask_byte_lane.sv
module vmask_byte_lane #(
  parameter int IDX_W = 5,
  parameter int VL_W  = 9
) (
  input  logic [7:0]       src_b,
  input  logic [7:0]       gov_b,
  input  logic [IDX_W-1:0] byte_idx,
  input  logic [VL_W-1:0]  vl_eff,
  output logic [7:0]       live,
  output logic [3:0]       live_cnt,
  output logic             live_hit,
  output logic [2:0]       live_off
);
  import vmask_scan_pkg::*;

  for (genvar k = 0; k < 8; k++) begin : g_elem
    logic [VL_W-1:0] elem_idx;
    assign elem_idx = VL_W'({byte_idx, 3'(k)});
    assign live[k]  = src_b[k] & gov_b[k] & (elem_idx < vl_eff);
  end

  assign live_cnt = ones_in_byte(live);
  assign live_hit = |live;
  assign live_off = low_bit(live);

endmodule

// File: rtl/vmask_scan_ctrl.sv
module vmask_scan_ctrl #(
  parameter int MAX_VL = 256,
  parameter int IDX_W  = 5,
  parameter int VL_W   = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             op_i,
  input  logic [31:0]      vl_i,
  input  logic             vstart_nz_i,
  input  logic [3:0]       live_cnt,
  input  logic             live_hit,
  input  logic [2:0]       live_off,
  output logic             accept,
  output logic             busy,
  output logic [IDX_W-1:0] byte_idx,
  output logic [VL_W-1:0]  vl_eff,
  output logic             done_o,
  output logic [31:0]      result_o,
  output logic             exc_o
);
  import vmask_scan_pkg::*;

  localparam logic [31:0] MAX_VL32 = 32'(MAX_VL);

  scan_op_e         op_q;
  logic [VL_W-1:0]  run_cnt;
  logic [VL_W-1:0]  cnt_next;
  logic [IDX_W-1:0] last_idx;
  logic [VL_W-1:0]  vl_clamped;
  logic             is_last;
  logic             first_hit;

  assign vl_clamped = (vl_i > MAX_VL32) ? VL_W'(MAX_VL) : vl_i[VL_W-1:0];
  assign accept     = start_i & ~busy;
  assign last_idx   = IDX_W'((vl_eff - 1'b1) >> 3);
  assign is_last    = (byte_idx == last_idx);
  assign first_hit  = (op_q == OP_FIRST) & live_hit;
  assign cnt_next   = run_cnt + VL_W'(live_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      op_q     <= OP_COUNT;
      vl_eff   <= '0;
      byte_idx <= '0;
      run_cnt  <= '0;
      done_o   <= 1'b0;
      exc_o    <= 1'b0;
      result_o <= '0;
    end else begin
      done_o <= 1'b0;
      exc_o  <= 1'b0;
      if (accept) begin
        op_q     <= scan_op_e'(op_i);
        vl_eff   <= vl_clamped;
        byte_idx <= '0;
        run_cnt  <= '0;
        if (vstart_nz_i) begin
          done_o   <= 1'b1;
          exc_o    <= 1'b1;
          result_o <= '0;
        end else if (vl_clamped == '0) begin
          done_o   <= 1'b1;
          result_o <= (op_i == OP_FIRST) ? '1 : '0;
        end else begin
          busy <= 1'b1;
        end
      end else if (busy) begin
        run_cnt <= cnt_next;
        if (first_hit) begin
          busy     <= 1'b0;
          done_o   <= 1'b1;
          result_o <= 32'({byte_idx, live_off});
        end else if (is_last) begin
          busy     <= 1'b0;
          done_o   <= 1'b1;
          result_o <= (op_q == OP_FIRST) ? '1 : 32'(cnt_next);
        end else begin
          byte_idx <= byte_idx + 1'b1;
        end
      end
    end
  end

  // R6: the exception flag travels only on a done pulse and carries no result
  a_r6_exc_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    exc_o |-> (done_o && result_o == '0));

  // R10: one byte per busy cycle
  a_r10_one_byte_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !done_o) |-> (byte_idx == $past(byte_idx) + 1'b1));

  // R4: running count never decreases during a scan
  a_r4_count_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (run_cnt >= $past(run_cnt)));

  // R4: reported count never exceeds the latched length
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !exc_o && op_q == OP_COUNT) |-> (result_o <= 32'(vl_eff)));

  // R5: a reported index lies below the latched length
  a_r5_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && op_q == OP_FIRST && result_o != '1) |-> (result_o < 32'(vl_eff)));

  // R9: done never appears while a scan is still running
  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy);

endmodule

// File: rtl/vmask_scan.sv
module vmask_scan #(
  parameter int MAX_VL = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              op_i,
  input  logic [MAX_VL-1:0] src_i,
  input  logic [MAX_VL-1:0] gov_i,
  input  logic [31:0]       vl_i,
  input  logic              vstart_nz_i,
  output logic              done_o,
  output logic [31:0]       result_o,
  output logic              exc_o
);
  localparam int NBYTES = MAX_VL / 8;
  localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam int VL_W   = $clog2(MAX_VL + 1);

  logic [MAX_VL-1:0] src_q, gov_q;
  logic              accept, busy;
  logic [IDX_W-1:0]  byte_idx;
  logic [VL_W-1:0]   vl_eff;
  logic [7:0]        src_b, gov_b, live;
  logic [3:0]        live_cnt;
  logic              live_hit;
  logic [2:0]        live_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      gov_q <= '0;
    end else if (accept) begin
      src_q <= src_i;
      gov_q <= gov_i;
    end
  end

  assign src_b = src_q[8*byte_idx +: 8];
  assign gov_b = gov_q[8*byte_idx +: 8];

  vmask_byte_lane #(.IDX_W(IDX_W), .VL_W(VL_W)) lane_i (
    .src_b    (src_b),
    .gov_b    (gov_b),
    .byte_idx (byte_idx),
    .vl_eff   (vl_eff),
    .live     (live),
    .live_cnt (live_cnt),
    .live_hit (live_hit),
    .live_off (live_off)
  );

  vmask_scan_ctrl #(.MAX_VL(MAX_VL), .IDX_W(IDX_W), .VL_W(VL_W)) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .op_i        (op_i),
    .vl_i        (vl_i),
    .vstart_nz_i (vstart_nz_i),
    .live_cnt    (live_cnt),
    .live_hit    (live_hit),
    .live_off    (live_off),
    .accept      (accept),
    .busy        (busy),
    .byte_idx    (byte_idx),
    .vl_eff      (vl_eff),
    .done_o      (done_o),
    .result_o    (result_o),
    .exc_o       (exc_o)
  );

  // R3: a live element always sits below the latched length
  a_r3_live_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && live_hit) |-> (32'({byte_idx, live_off}) < 32'(vl_eff)));

  // R2: a live element needs both mask bits
  a_r2_live_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((live & ~(src_b & gov_b)) == 8'h00));

endmodule

// File: tb/vmask_scan_tb_top.sv
module vmask_scan_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_VL     = 256;

  typedef struct {
    logic [31:0] res;
    logic        exc;
    int          lat;
    string       tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic              op_i = 1'b0;
  logic [MAX_VL-1:0] src_i = '0;
  logic [MAX_VL-1:0] gov_i = '0;
  logic [31:0]       vl_i = '0;
  logic              vstart_nz_i = 1'b0;
  logic              done_o;
  logic [31:0]      result_o;
  logic              exc_o;

  int   checks = 0;
  int   failures = 0;
  int   cyc = 0;
  int   start_cyc = 0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vmask_scan #(.MAX_VL(MAX_VL)) dut_i (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expectations as results appear
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (sb.size() == 0) begin
        check(1'b0, "R9 unexpected done", result_o, 32'hx);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(result_o == e.res, {e.tag, " result"}, result_o, e.res);
        check(exc_o == e.exc, {e.tag, " exc"}, 32'(exc_o), 32'(e.exc));
        check((cyc - start_cyc) == e.lat, {e.tag, " R10 latency"}, 32'(cyc - start_cyc), 32'(e.lat));
      end
    end
  end

  task automatic issue(input bit op, input logic [MAX_VL-1:0] s, input logic [MAX_VL-1:0] g,
                       input logic [31:0] vl, input bit vsnz, input string tag);
    exp_t e;
    int   veff, cnt, first;
    veff  = (vl > MAX_VL) ? MAX_VL : int'(vl);
    cnt   = 0;
    first = -1;
    for (int i = 0; i < veff; i++)
      if (s[i] && g[i]) begin
        cnt++;
        if (first < 0) first = i;
      end
    e.tag = tag;
    e.exc = vsnz;
    if (vsnz) begin
      e.res = 0; e.lat = 1;
    end else if (veff == 0) begin
      e.res = op ? 32'hFFFF_FFFF : 0; e.lat = 1;
    end else if (op && first >= 0) begin
      e.res = first; e.lat = first / 8 + 2;
    end else begin
      e.res = op ? 32'hFFFF_FFFF : cnt; e.lat = (veff + 7) / 8 + 1;
    end
    sb.push_back(e);
    @(negedge clk);
    start_i = 1'b1; op_i = op; src_i = s; gov_i = g; vl_i = vl; vstart_nz_i = vsnz;
    start_cyc = cyc;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [MAX_VL-1:0] pattern(input int seed);
    logic [MAX_VL-1:0] v;
    logic [31:0] x;
    x = 32'h1234_5678 ^ seed;
    for (int i = 0; i < MAX_VL; i++) begin
      x = {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
      v[i] = x[3];
    end
    return v;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check(done_o == 0 && exc_o == 0 && result_o == 0, "R11 reset outputs", result_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 full count, all ones
    issue(0, '1, '1, 256, 0, "R4 full count"); drain();
    // R1 element mapping: only element 9 (byte 1 bit 1)
    issue(1, MAX_VL'(1) << 9, '1, 256, 0, "R1 R5 first at 9"); drain();
    issue(0, MAX_VL'(1) << 9, '1, 256, 0, "R1 count single"); drain();
    // R2: masks disjoint -> nothing
    issue(0, {MAX_VL/2{2'b01}}, {MAX_VL/2{2'b10}}, 256, 0, "R2 disjoint count"); drain();
    issue(1, {MAX_VL/2{2'b01}}, {MAX_VL/2{2'b10}}, 256, 0, "R2 R5 disjoint miss"); drain();
    // R2 alternating overlap
    issue(0, {MAX_VL/2{2'b11}}, {MAX_VL/2{2'b10}}, 256, 0, "R2 half count"); drain();
    // R3: bits above vl ignored
    issue(0, '1, '1, 13, 0, "R3 vl13 count"); drain();
    issue(1, MAX_VL'(1) << 13, '1, 13, 0, "R3 R5 at vl boundary"); drain();
    issue(1, MAX_VL'(1) << 12, '1, 13, 0, "R3 R5 last in range"); drain();
    // R5 high index, R10 early stop
    issue(1, MAX_VL'(1) << 200, '1, 256, 0, "R5 R10 first at 200"); drain();
    issue(1, MAX_VL'(1) << 255, '1, 256, 0, "R5 first at top"); drain();
    // random patterns
    for (int k = 0; k < 6; k++) begin
      issue(k % 2, pattern(k), pattern(k + 77), 32'(37 * k + 5), 0, "R4 R5 random"); drain();
    end
    // R6 exception
    issue(0, '1, '1, 256, 1, "R6 vstart count"); drain();
    issue(1, '1, '1, 256, 1, "R6 vstart first"); drain();
    // R7 zero length
    issue(0, '1, '1, 0, 0, "R7 vl0 count"); drain();
    issue(1, '1, '1, 0, 0, "R7 vl0 first"); drain();
    // R8 clamp
    issue(0, '1, '1, 1000, 0, "R8 clamp count"); drain();
    issue(1, '0, '1, 32'hFFFF_FFFF, 0, "R8 clamp miss"); drain();
    // R9 start while busy is ignored
    issue(0, '1, {MAX_VL/2{2'b01}}, 256, 0, "R9 busy count");
    repeat (3) @(negedge clk);
    start_i = 1'b1; op_i = 1'b1; src_i = '0; gov_i = '0; vl_i = 1; vstart_nz_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; vstart_nz_i = 1'b0;
    drain();
    repeat (40) @(negedge clk);
    check(sb.size() == 0, "R9 no extra result", 32'(sb.size()), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule